// File: doc/BRIEF.md
# Serial Receive Word Buffer with Split Interrupts

This block sits between a serial receive shifter and a host read port. Each time the shifter finishes a word, it raises a one-cycle completion strobe with the word. The buffer stores the word. The host takes words out with a read strobe. The oldest stored word is always presented on the read data port.

Two storage modes are available. In buffered mode the words go into an eight-entry queue. When the queue is full, one more word can wait in a park register that stands for the shifter. In bypass mode only one word is held, and it must be taken before another can enter.

The block raises a receive interrupt from a mode-dependent flag:
- In buffered mode the flag is queue-full.
- In bypass mode the flag is data-ready.

The interrupt leaves on one of two lines, depending on whether a sticky overrun exception is pending.

Top module: `rx_word_buffer`

## Requirements
- R1: With `fifo_en`=1, up to DEPTH (8) words are kept. `rd_data` always shows the oldest kept word. A `rd_stb` pulse while `data_rdy`=1 removes that word, so words are read back in arrival order.
- R2: With `fifo_en`=1 and all DEPTH entries filled, the next completed word is parked and is not lost. On the clock after a read frees an entry, the parked word enters the queue. It is read after all older words.
- R3: With `fifo_en`=0 only one word is held. A word that completes while that word is unread is discarded, `overrun` is set, and `rd_data` keeps the held word.
- R4: A word that completes while a parked word still waits is discarded and sets `overrun`. `overrun` stays at 1 until a cycle with `ovr_clr`=1 and no new overrun. A new overrun in the same cycle as `ovr_clr` keeps it at 1.
- R5: `data_rdy` is 1 exactly when at least one word can be read. `fifo_full` is 1 exactly when DEPTH words are queued. Both flags are registered and change on the clock edge that captures the push or the read.
- R6: The interrupt source flag is `fifo_full` when `fifo_en`=1 and `data_rdy` when `fifo_en`=0. It can reach an interrupt line only while both `rx_en`=1 and `irq_en`=1.
- R7: An active interrupt appears on `irq_rx` when `overrun`=0 and on `irq_rx_exc` when `overrun`=1. The two lines are never high together.
- R8: `rx_en`=0 flushes every stored and parked word and clears `overrun`. While it is 0, completed words and reads are ignored.
- R9: A read strobe with no readable word has no effect. A later single word is read back once, and `data_rdy` then falls.
- R10: After reset, `data_rdy`, `fifo_full`, `overrun`, `irq_rx` and `irq_rx_exc` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| fifo_en | input | 1 | 1 = eight-entry queue, 0 = single register |
| irq_en | input | 1 | Receive interrupt enable |
| word_valid | input | 1 | One-cycle strobe: shifter completed a word |
| word_data | input | DATA_W | Completed word from the shifter |
| rd_stb | input | 1 | Host read strobe, removes the oldest word |
| ovr_clr | input | 1 | Clears the overrun exception |
| rd_data | output | DATA_W | Oldest readable word |
| data_rdy | output | 1 | At least one word readable |
| fifo_full | output | 1 | DEPTH words queued |
| overrun | output | 1 | Sticky overrun exception |
| irq_rx | output | 1 | Receive interrupt, no exception |
| irq_rx_exc | output | 1 | Receive interrupt with exception |

## Verification
The storage path is exercised with four input patterns:
- A short burst followed by reads confirms ordering and the flags below capacity.
- An exact fill to eight words, then a ninth, separates a correct park from a drop or an early overwrite. The bench then reads one word and watches `fifo_full` for one cycle as the parked word moves in.
- A tenth word on top of a park, and a second word in bypass, tell an overrun that discards the new word apart from one that corrupts held data.
- A strobe on an empty buffer, and words offered while the receiver is disabled, show that these stimuli leave the flags and read data unchanged.

The interrupt lines are checked in both modes, with the enable on and off, and with and without a pending exception.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned RXB_DATA_W = 16;
  localparam int unsigned RXB_DEPTH  = 8;

  typedef struct packed {
    logic rdy;
    logic full;
    logic ovr;
  } rxb_flags_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          push,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop,
  output logic [DATA_W-1:0]             rd_data,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage entries: per-entry write enable, no reset on data
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && !flush && (wr_ptr_q == PTR_W'(g))) begin
        mem_q[g] <= push_data;
      end
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign rd_data = mem_q[rd_ptr_q];
  assign count   = cnt_q;
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx_en,
  input  logic                          fifo_en,
  input  logic                          word_valid,
  input  logic [DATA_W-1:0]             word_data,
  input  logic                          rd_stb,
  input  logic                          ovr_clr,
  input  logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          flush,
  output logic                          push,
  output logic [DATA_W-1:0]             push_data,
  output logic                          pop,
  output rxb_flags_t                    flags
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic              park_vld_q, park_vld_d;
  logic [DATA_W-1:0] park_dat_q, park_dat_d;
  logic              park_ld;
  logic              ovr_q, ovr_d;
  logic              ovr_set;
  logic              cap_full;
  logic              wv;

  always_comb begin
    flush     = !rx_en;
    wv        = rx_en && word_valid;
    cap_full  = fifo_en ? (count == FULL_CNT) : (count != '0);
    pop       = rx_en && rd_stb && (count != '0);
    push      = 1'b0;
    push_data = word_data;
    park_ld   = 1'b0;
    ovr_set   = 1'b0;
    park_vld_d = park_vld_q;
    if (flush) begin
      park_vld_d = 1'b0;
    end else if (park_vld_q) begin
      // a waiting word has priority; any new word is lost
      if (count != FULL_CNT) begin
        push       = 1'b1;
        push_data  = park_dat_q;
        park_vld_d = 1'b0;
      end
      ovr_set = wv;
    end else if (wv) begin
      if (!cap_full) begin
        push = 1'b1;
      end else if (fifo_en) begin
        park_ld    = 1'b1;
        park_vld_d = 1'b1;
      end else begin
        ovr_set = 1'b1;
      end
    end
  end

  always_comb begin
    park_dat_d = park_ld ? word_data : park_dat_q;
    if (flush)        ovr_d = 1'b0;
    else if (ovr_set) ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
    else              ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_vld_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      park_vld_q <= park_vld_d;
      ovr_q      <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (park_ld) park_dat_q <= park_dat_d;
  end

  assign flags.rdy  = (count != '0);
  assign flags.full = (count == FULL_CNT);
  assign flags.ovr  = ovr_q;
endmodule

// File: rtl/rxb_irq.sv
module rxb_irq
  import rxb_pkg::*;
(
  input  logic       rx_en,
  input  logic       fifo_en,
  input  logic       irq_en,
  input  rxb_flags_t flags,
  output logic       irq_rx,
  output logic       irq_rx_exc
);
  logic src;
  logic active;

  always_comb begin
    src        = fifo_en ? flags.full : flags.rdy;
    active     = rx_en && irq_en && src;
    irq_rx     = active && !flags.ovr;
    irq_rx_exc = active && flags.ovr;
  end
endmodule

// File: rtl/rx_word_buffer.sv
module rx_word_buffer
  import rxb_pkg::*;
#(
  parameter int unsigned DATA_W = RXB_DATA_W,
  parameter int unsigned DEPTH  = RXB_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              fifo_en,
  input  logic              irq_en,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_rdy,
  output logic              fifo_full,
  output logic              overrun,
  output logic              irq_rx,
  output logic              irq_rx_exc
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  occ;
  logic              flush;
  logic              push;
  logic              pop;
  logic [DATA_W-1:0] push_data;
  rxb_flags_t        flags;

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .rd_data   (rd_data),
    .count     (occ)
  );

  rxb_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .fifo_en    (fifo_en),
    .word_valid (word_valid),
    .word_data  (word_data),
    .rd_stb     (rd_stb),
    .ovr_clr    (ovr_clr),
    .count      (occ),
    .flush      (flush),
    .push       (push),
    .push_data  (push_data),
    .pop        (pop),
    .flags      (flags)
  );

  rxb_irq irq_i (
    .rx_en      (rx_en),
    .fifo_en    (fifo_en),
    .irq_en     (irq_en),
    .flags      (flags),
    .irq_rx     (irq_rx),
    .irq_rx_exc (irq_rx_exc)
  );

  assign data_rdy  = flags.rdy;
  assign fifo_full = flags.full;
  assign overrun   = flags.ovr;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       fifo_en,
  input logic                       irq_en,
  input logic                       rd_stb,
  input logic                       ovr_clr,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       data_rdy,
  input logic                       overrun,
  input logic                       irq_rx,
  input logic                       irq_rx_exc,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH+1))'(DEPTH));

  a_r3_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !fifo_en && data_rdy && !rd_stb) |=> $stable(rd_data));

  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && overrun && !ovr_clr) |=> overrun);

  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx || irq_rx_exc) |-> (rx_en && irq_en));

  a_r7_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_rx_exc));

  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!data_rdy && !overrun));
endmodule

bind rx_word_buffer rxb_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .fifo_en    (fifo_en),
  .irq_en     (irq_en),
  .rd_stb     (rd_stb),
  .ovr_clr    (ovr_clr),
  .rd_data    (rd_data),
  .data_rdy   (data_rdy),
  .overrun    (overrun),
  .irq_rx     (irq_rx),
  .irq_rx_exc (irq_rx_exc),
  .occ        (occ)
);

// File: tb/rx_word_buffer_tb_top.sv
module rx_word_buffer_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0, fifo_en = 1'b0, irq_en = 1'b0;
  logic          word_valid = 1'b0, rd_stb = 1'b0, ovr_clr = 1'b0;
  logic [DW-1:0] word_data = '0;
  logic [DW-1:0] rd_data;
  logic          data_rdy, fifo_full, overrun, irq_rx, irq_rx_exc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_word_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_en(fifo_en), .irq_en(irq_en),
    .word_valid(word_valid), .word_data(word_data), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .data_rdy(data_rdy), .fifo_full(fifo_full), .overrun(overrun),
    .irq_rx(irq_rx), .irq_rx_exc(irq_rx_exc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // inputs change and outputs are sampled at the falling edge
  task automatic push_word(input logic [DW-1:0] d);
    @(negedge clk); word_valid = 1'b1; word_data = d;
    @(negedge clk); word_valid = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [DW-1:0] exp);
    @(negedge clk);
    chk(req, "rdy before read", int'(data_rdy), 1);
    chk(req, "rd_data", int'(rd_data), int'(exp));
    rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic clear_ovr;
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
  endtask

  task automatic restart(input logic fmode, input logic ien);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); fifo_en = fmode; irq_en = ien; rx_en = 1'b1;
  endtask

  task automatic t_reset;
    chk("R10", "data_rdy", int'(data_rdy), 0);
    chk("R10", "fifo_full", int'(fifo_full), 0);
    chk("R10", "overrun", int'(overrun), 0);
    chk("R10", "irq lines", int'({irq_rx, irq_rx_exc}), 0);
  endtask

  task automatic t_fifo_order;
    restart(1'b1, 1'b1);
    push_word(16'h1111); push_word(16'h2222); push_word(16'h3333);
    chk("R5", "rdy after burst", int'(data_rdy), 1);
    chk("R5", "full after burst", int'(fifo_full), 0);
    chk("R6", "irq below capacity", int'(irq_rx), 0);
    read_expect("R1", 16'h1111); read_expect("R1", 16'h2222); read_expect("R1", 16'h3333);
    chk("R5", "rdy after drain", int'(data_rdy), 0);
  endtask

  task automatic t_full_park;
    restart(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) push_word(16'hA000 + DW'(i));
    chk("R5", "full at eight", int'(fifo_full), 1);
    chk("R6", "irq_rx on full", int'(irq_rx), 1);
    push_word(16'hA008);
    chk("R2", "no overrun on ninth", int'(overrun), 0);
    chk("R2", "head unchanged", int'(rd_data), 16'hA000);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R5", "full drops after read", int'(fifo_full), 0);
    @(negedge clk);
    chk("R2", "parked word moved in", int'(fifo_full), 1);
    for (int i = 1; i < 9; i++) read_expect("R2", 16'hA000 + DW'(i));
    chk("R2", "empty after drain", int'(data_rdy), 0);
  endtask

  task automatic t_overrun_park;
    restart(1'b1, 1'b1);
    for (int i = 0; i < 9; i++) push_word(16'hB000 + DW'(i));
    push_word(16'hB009);
    chk("R4", "overrun on tenth", int'(overrun), 1);
    chk("R7", "irq_rx_exc", int'(irq_rx_exc), 1);
    chk("R7", "irq_rx off", int'(irq_rx), 0);
    repeat (3) @(negedge clk);
    chk("R4", "overrun sticky", int'(overrun), 1);
    clear_ovr();
    chk("R4", "overrun cleared", int'(overrun), 0);
    chk("R7", "irq_rx back", int'(irq_rx), 1);
    @(negedge clk); word_valid = 1'b1; word_data = 16'hBEEF; ovr_clr = 1'b1;
    @(negedge clk); word_valid = 1'b0; ovr_clr = 1'b0;
    chk("R4", "set beats clear", int'(overrun), 1);
    for (int i = 0; i < 9; i++) read_expect("R4", 16'hB000 + DW'(i));
    chk("R4", "lost words not stored", int'(data_rdy), 0);
  endtask

  task automatic t_bypass;
    restart(1'b0, 1'b1);
    push_word(16'hC001);
    chk("R6", "bypass irq on rdy", int'(irq_rx), 1);
    chk("R5", "bypass full flag", int'(fifo_full), 0);
    push_word(16'hC002);
    chk("R3", "bypass overrun", int'(overrun), 1);
    chk("R7", "bypass exc irq", int'(irq_rx_exc), 1);
    read_expect("R3", 16'hC001);
    chk("R3", "second word lost", int'(data_rdy), 0);
    clear_ovr();
    push_word(16'hC003);
    read_expect("R3", 16'hC003);
  endtask

  task automatic t_irq_gate;
    restart(1'b0, 1'b0);
    push_word(16'hD001);
    chk("R6", "irq masked", int'({irq_rx, irq_rx_exc}), 0);
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk("R6", "irq unmasked", int'(irq_rx), 1);
  endtask

  task automatic t_flush;
    restart(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) push_word(16'hE000 + DW'(i));
    chk("R8", "pre flush overrun", int'(overrun), 1);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R8", "flushed rdy", int'(data_rdy), 0);
    chk("R8", "flushed overrun", int'(overrun), 0);
    push_word(16'hE0FF);
    chk("R8", "word ignored while off", int'(data_rdy), 0);
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    chk("R8", "empty after enable", int'(data_rdy), 0);
    chk("R8", "no parked leftover", int'(fifo_full), 0);
  endtask

  task automatic t_empty_read;
    restart(1'b1, 1'b0);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R9", "empty read rdy", int'(data_rdy), 0);
    push_word(16'hF00D);
    read_expect("R9", 16'hF00D);
    chk("R9", "single read empties", int'(data_rdy), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo_order();
    t_full_park();
    t_overrun_park();
    t_bypass();
    t_irq_gate();
    t_flush();
    t_empty_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule